// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder/Subtractor

This block is a purely combinational 16-bit adder/subtractor. The operand width is cut into four 4-bit slices. Each slice finds its own internal carries by lookahead and reports a slice generate and a slice propagate flag. A second lookahead stage takes those four flag pairs and the forced carry. From them it forms the carries into slices 1, 2 and 3 at the same time. It also forms the final carry-out. No carry ripples from one slice to the next.

In subtract mode the second operand is inverted bit by bit and the forced carry is held at one, so the block returns the two's complement difference. The second stage also exposes a generate/propagate pair that covers the whole 16-bit section. Four copies of the block can then be joined by one more lookahead stage to form a 64-bit adder. Per bit, generate is the AND of the two operand bits and propagate is their OR.

Top module: `cla_addsub16`

## Requirements
- R1: For every bit position i, the carry into bit i+1 equals (x_i AND y'_i) OR (c_i AND (x_i OR y'_i)), where y' is the second operand after optional inversion and c_0 is the forced carry.
- R2: With `sub_mode` = 0, `sum` = (x + y + `carry_in`) mod 65536 and `carry_out` is bit 16 of that unsigned total.
- R3: With `sub_mode` = 1, `sum` = (x − y) mod 65536 and `carry_out` = 1 exactly when x ≥ y as unsigned values; `carry_in` has no effect on any output.
- R4: The carries into bit positions 4, 8 and 12 come from the group lookahead stage and match the ripple value, so a carry made in one slice reaches every higher slice (for example 0x0FFF + 0x0001 = 0x1000).
- R5: `sec_gen` = 1 exactly when x + y' with a zero forced carry overflows 16 bits.
- R6: `sec_prop` = 1 exactly when x_i OR y'_i is 1 at every one of the 16 positions.
- R7: `carry_out` = `sec_gen` OR (`sec_prop` AND c_0).
- R8: In subtract mode, 0x0005 minus 0x0002 yields `sum` = 0x0003 with `carry_out` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | First operand (minuend when subtracting) |
| y | input | 16 | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Forced carry into bit 0 in add mode |
| sub_mode | input | 1 | 1 selects x − y, 0 selects x + y + carry_in |
| sum | output | 16 | Result, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| sec_gen | output | 1 | Section generate over all 16 bits |
| sec_prop | output | 1 | Section propagate over all 16 bits |

## Verification
The first set of patterns is a table of hand-picked operand pairs. These separate add from subtract and show whether the forced carry is honoured or ignored. The carry-chain corners test R4 and R7 directly. All-ones plus one and 0xAAAA + 0x5555 with a carry-in both drive one carry through every slice and through the second stage. Pairs such as 0x0FFF + 1 stop the carry at a chosen slice boundary. Pseudo-random operand pairs in both modes then compare the result, carry-out and section flags with plain integer arithmetic.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int GRP_W   = 4;
  localparam int N_GRP   = 4;
  localparam int TOTAL_W = GRP_W * N_GRP;

  // Sum-of-products carries: c[k+1] depends only on g, p and cin, never on c[k]
  function automatic logic [GRP_W:0] la_carries(input logic [GRP_W-1:0] g,
                                                input logic [GRP_W-1:0] p,
                                                input logic cin);
    logic [GRP_W:0] c;
    logic acc;
    logic term;
    c[0] = cin;
    for (int k = 0; k < GRP_W; k++) begin
      acc = cin;
      for (int j = 0; j <= k; j++) acc = acc & p[j];
      for (int j = 0; j <= k; j++) begin
        term = g[j];
        for (int m = j + 1; m <= k; m++) term = term & p[m];
        acc = acc | term;
      end
      c[k+1] = acc;
    end
    return c;
  endfunction

  function automatic logic grp_generate(input logic [GRP_W-1:0] g,
                                        input logic [GRP_W-1:0] p);
    logic [GRP_W:0] c;
    c = la_carries(g, p, 1'b0);
    return c[GRP_W];
  endfunction

  function automatic logic grp_propagate(input logic [GRP_W-1:0] p);
    return &p;
  endfunction
endpackage

// File: rtl/cla_group.sv
module cla_group
  import cla_pkg::*;
(
  input  logic [GRP_W-1:0] a,
  input  logic [GRP_W-1:0] b,
  input  logic             cin,
  output logic [GRP_W-1:0] s,
  output logic             gg,
  output logic             pg
);
  logic [GRP_W-1:0] g_bit;
  logic [GRP_W-1:0] p_bit;
  logic [GRP_W:0]   c_int;

  always_comb begin
    g_bit = a & b;
    p_bit = a | b;
    c_int = la_carries(g_bit, p_bit, cin);
    s     = a ^ b ^ c_int[GRP_W-1:0];
    gg    = grp_generate(g_bit, p_bit);
    pg    = grp_propagate(p_bit);
    for (int k = 0; k < GRP_W; k++) begin
      // R1
      ripple_carry_chk: assert (c_int[k+1] == ((a[k] & b[k]) | (c_int[k] & (a[k] | b[k]))));
    end
    // R7
    group_cout_chk: assert (c_int[GRP_W] == (gg | (pg & cin)));
  end
endmodule

// File: rtl/cla_gen.sv
module cla_gen
  import cla_pkg::*;
(
  input  logic [N_GRP-1:0] gg,
  input  logic [N_GRP-1:0] pg,
  input  logic             c0,
  output logic [N_GRP-1:0] grp_cin,
  output logic             c_out,
  output logic             sec_g,
  output logic             sec_p
);
  logic [N_GRP:0] c_grp;

  always_comb begin
    c_grp   = la_carries(gg, pg, c0);
    grp_cin = c_grp[N_GRP-1:0];
    c_out   = c_grp[N_GRP];
    sec_g   = grp_generate(gg, pg);
    sec_p   = grp_propagate(pg);
    for (int k = 0; k < N_GRP; k++) begin
      // R4
      group_carry_chk: assert (c_grp[k+1] == (gg[k] | (pg[k] & c_grp[k])));
    end
    // R7
    section_cout_chk: assert (c_out == (sec_g | (sec_p & c0)));
    // R6
    section_prop_chk: assert (!sec_p || (pg == '1));
  end
endmodule

// File: rtl/cla_addsub16.sv
module cla_addsub16
  import cla_pkg::*;
(
  input  logic [TOTAL_W-1:0] x,
  input  logic [TOTAL_W-1:0] y,
  input  logic               carry_in,
  input  logic               sub_mode,
  output logic [TOTAL_W-1:0] sum,
  output logic               carry_out,
  output logic               sec_gen,
  output logic               sec_prop
);
  logic [TOTAL_W-1:0] y_eff;
  logic               c0;
  logic [N_GRP-1:0]   grp_g;
  logic [N_GRP-1:0]   grp_p;
  logic [N_GRP-1:0]   grp_cin;

  assign y_eff = y ^ {TOTAL_W{sub_mode}};
  assign c0    = sub_mode | carry_in;

  for (genvar gi = 0; gi < N_GRP; gi++) begin : g_slice
    cla_group u_grp (
      .a   (x[gi*GRP_W +: GRP_W]),
      .b   (y_eff[gi*GRP_W +: GRP_W]),
      .cin (grp_cin[gi]),
      .s   (sum[gi*GRP_W +: GRP_W]),
      .gg  (grp_g[gi]),
      .pg  (grp_p[gi])
    );
  end

  cla_gen u_gen (
    .gg      (grp_g),
    .pg      (grp_p),
    .c0      (c0),
    .grp_cin (grp_cin),
    .c_out   (carry_out),
    .sec_g   (sec_gen),
    .sec_p   (sec_prop)
  );
endmodule

// File: tb/cla_addsub16_tb.sv
module cla_addsub16_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] x = '0, y = '0;
  logic        carry_in = 1'b0, sub_mode = 1'b0;
  logic [15:0] sum;
  logic        carry_out, sec_gen, sec_prop;
  int          total = 0, bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  cla_addsub16 u_dut (
    .x(x), .y(y), .carry_in(carry_in), .sub_mode(sub_mode),
    .sum(sum), .carry_out(carry_out), .sec_gen(sec_gen), .sec_prop(sec_prop)
  );

  // fields: x, y, carry_in, sub_mode
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {16'h0005, 16'h0002, 1'b0, 1'b1},  // R8
    {16'h1234, 16'h4321, 1'b0, 1'b0},  // R2
    {16'h1234, 16'h4321, 1'b1, 1'b0},  // R2 carry_in honoured
    {16'h0002, 16'h0005, 1'b0, 1'b1},  // R3 borrow
    {16'h0002, 16'h0005, 1'b1, 1'b1},  // R3 carry_in ignored
    {16'h8000, 16'h8000, 1'b0, 1'b0},  // R5 top-bit generate
    {16'h0FFF, 16'h0001, 1'b0, 1'b0},  // R4 into slice 3
    {16'h00FF, 16'h0001, 1'b0, 1'b0},  // R4 into slice 2
    {16'h000F, 16'h0000, 1'b1, 1'b0},  // R4 into slice 1 via carry_in
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0},  // R2 max
    {16'h7FFF, 16'h7FFF, 1'b0, 1'b1},  // R3 equal operands
    {16'hF0F0, 16'h0F0F, 1'b0, 1'b0}   // R6 propagate without generate
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (x=%h y=%h cin=%b sub=%b)",
               req, got, exp, x, y, carry_in, sub_mode);
    end
  endtask

  task automatic apply_and_check(input logic [15:0] xa, input logic [15:0] ya,
                                 input logic ci, input logic sb);
    logic [15:0] ye;
    logic [16:0] full, nocarry;
    logic        c0;
    @(negedge clk);
    x = xa; y = ya; carry_in = ci; sub_mode = sb;
    ye      = sb ? ~ya : ya;
    c0      = sb ? 1'b1 : ci;
    full    = {1'b0, xa} + {1'b0, ye} + {16'd0, c0};
    nocarry = {1'b0, xa} + {1'b0, ye};
    @(posedge clk); #2;
    chk(sb ? "R3 sum" : "R2 sum", {16'd0, sum}, {16'd0, full[15:0]});
    chk("R1/R7 carry_out", {31'd0, carry_out}, {31'd0, full[16]});
    chk("R5 sec_gen", {31'd0, sec_gen}, {31'd0, nocarry[16]});
    chk("R6 sec_prop", {31'd0, sec_prop}, {31'd0, &(xa | ye)});
    if (sb) chk("R3 borrow", {31'd0, carry_out}, {31'd0, (xa >= ya)});
  endtask

  initial begin
    logic [31:0] lfsr;
    lfsr = 32'h1ACE_B00C;
    repeat (3) @(posedge clk);
    #2;
    chk("reset sum", {16'd0, sum}, 32'd0);
    chk("reset carry_out", {31'd0, carry_out}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < NV; i++)
      apply_and_check(VEC[i][33:18], VEC[i][17:2], VEC[i][1], VEC[i][0]);
    // R8 explicit example
    apply_and_check(16'h0005, 16'h0002, 1'b0, 1'b1);
    chk("R8 diff", {16'd0, sum}, 32'h0003);
    // R4 all-ones plus one: carry through every slice
    apply_and_check(16'hFFFF, 16'h0001, 1'b0, 1'b0);
    chk("R4 wrap", {15'd0, carry_out, sum}, 32'h0001_0000);
    // R4 full propagate chain fed by carry_in
    apply_and_check(16'hAAAA, 16'h5555, 1'b1, 1'b0);
    chk("R7 chain", {14'd0, sec_prop, carry_out, sum}, 32'h0003_0000);
    // zero operands in both modes
    apply_and_check(16'h0000, 16'h0000, 1'b0, 1'b0);
    apply_and_check(16'h0000, 16'h0000, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = lfsr * 32'd1103515245 + 32'd12345;
      apply_and_check(lfsr[31:16], lfsr[15:0], lfsr[3], lfsr[9]);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule